// File: doc/BRIEF.md
# Endian-Selectable Load/Store Byte-Lane Steering

This block sits between a 32-bit register file and a 32-bit memory bus whose byte lanes are fixed to addresses: the byte at address offset k always travels on lane k. Lane 0 is bits 7:0, lane 1 is 15:8, lane 2 is 23:16 and lane 3 is 31:24. Each request gives an access size, the two low address bits, a direction, a transaction class and a single mode bit. The block produces the lane-ordered store data, the lane byte enables and a zero-extended load result. The mode bit decides whether the low-order register byte sits at the lowest address (little endian) or the highest address (big endian) of the accessed unit.

Plain register-space accesses are never reordered, whatever the mode. The one designated data-port register is reordered exactly like memory. Misaligned requests are flagged and produce no lane activity. All results are registered and appear one cycle after the request strobe. They hold until the next strobe.

Top module: `lane_steer`

## Requirements
- R1: Byte enables mark exactly the lanes touched. A byte at offset k gives only bit k. A half-word at offset 0 gives 4'b0011 and at offset 2 gives 4'b1100. A word at offset 0 gives 4'b1111. Size encoding: 0 byte, 1 half-word, 2 word, 3 reserved.
- R2: With `little_en`=1 and a memory-class store, register byte i goes to lane (offset+i). A word 0x01020304 appears unchanged on the bus, and a half-word at offset 2 places register bits 15:0 on bits 31:16.
- R3: With `little_en`=0 and a memory-class store, register byte i goes to lane (offset+size_bytes-1-i). A word reverses byte order. A half-word puts its high byte on the lower lane. A byte at offset k still uses lane k.
- R4: Loads take data from the enabled lanes with the inverse mapping of R2/R3, zero-extended to 32 bits. Suppose a word 0x04050607 was stored in either mode. A word load returns 0x04050607, and a byte load at offset 0 returns 0x04 with `little_en`=0 and 0x07 with `little_en`=1.
- R5: Class encoding: 0 memory, 1 register space, 2 data port, 3 treated as memory. Class 1 always uses the little-endian (identity) mapping, whatever the mode. Classes 0, 2 and 3 follow the mode bit.
- R6: A half-word at an odd offset, a word at a non-zero offset, and size 3 all raise `misalign`. For such a request the byte enables, the store data and the load result are all zero.
- R7: A load drives zero store data and ignores `st_data`. A store returns a zero load result and ignores `bus_rdata`.
- R8: Outputs update one cycle after a clock edge with `req_en` high, and `out_vld` is high for that one cycle. While `req_en` is low, the other outputs hold their values.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_en | input | 1 | Request strobe, also the register clock enable |
| req_store | input | 1 | 1 store, 0 load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_ofs | input | 2 | Low address bits |
| req_cls | input | 2 | 0 memory, 1 register space, 2 data port, 3 as memory |
| little_en | input | 1 | 1 little endian, 0 big endian |
| st_data | input | 32 | Register value to store, low-aligned |
| bus_rdata | input | 32 | Lane-ordered read data for loads |
| bus_wdata | output | 32 | Lane-ordered store data |
| bus_be | output | 4 | Lane byte enables |
| misalign | output | 1 | Misaligned or reserved-size request |
| ld_data | output | 32 | Zero-extended load result |
| out_vld | output | 1 | Results updated this cycle |

## Verification
The steering is tried with word, half-word and byte accesses at each legal offset in both modes. Distinct byte values in every position mean that any lane reversal or shift error shows as a wrong byte, not only a wrong enable. The 0x04050607 pattern is stored in one mode and loaded back in the same mode, which separates the two byte orders for single-byte loads and confirms that word round trips agree. Each class is given a big-endian word or half-word. These patterns separate the register-space bypass from the data-port and reserved-class swap. Odd and reserved size/offset pairs, and loads or stores with all-ones data on the unused path, show whether misaligned or unused data leaks to the outputs.

// File: rtl/lsteer_pkg.sv
package lsteer_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    CL_MEM  = 2'd0,
    CL_REGS = 2'd1,
    CL_PORT = 2'd2,
    CL_RSVD = 2'd3
  } acc_class_e;

endpackage

// File: rtl/lsteer_decode.sv
module lsteer_decode #(
  parameter int LANES = 4,
  localparam int OFS_W = $clog2(LANES),
  localparam int CNT_W = OFS_W + 2
) (
  input  logic [1:0]       size,
  input  logic [OFS_W-1:0] ofs,
  input  logic [1:0]       cls,
  input  logic             little,
  output logic [LANES-1:0] be,
  output logic             misalign,
  output logic             swap,
  output logic [OFS_W-1:0] last
);
  import lsteer_pkg::*;

  logic [CNT_W-1:0] span;
  logic [CNT_W-1:0] ofs_x;

  always_comb begin
    span     = CNT_W'(1) << size;
    ofs_x    = CNT_W'(ofs);
    misalign = (span > CNT_W'(LANES)) || ((ofs_x & (span - CNT_W'(1))) != '0);
    last     = OFS_W'(span - CNT_W'(1));
    // register space always keeps identity order (R5)
    swap     = !little && (acc_class_e'(cls) != CL_REGS);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_be
    assign be[l] = !misalign && (CNT_W'(l) >= ofs_x) && (CNT_W'(l) < ofs_x + span);
  end

endmodule

// File: rtl/lsteer_wr_mux.sv
module lsteer_wr_mux #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFS_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] src,
  input  logic [LANES-1:0]  be,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [OFS_W-1:0]  last,
  input  logic              swap,
  output logic [DATA_W-1:0] lanes
);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [OFS_W-1:0] idx;
    always_comb begin
      if (swap) idx = ofs + last - OFS_W'(l);
      else      idx = OFS_W'(l) - ofs;
      lanes[l*LANE_W +: LANE_W] = be[l] ? src[idx*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/lsteer_rd_mux.sv
module lsteer_rd_mux #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFS_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [DATA_W-1:0] lanes,
  input  logic              misalign,
  input  logic [OFS_W-1:0]  ofs,
  input  logic [OFS_W-1:0]  last,
  input  logic              swap,
  output logic [DATA_W-1:0] dst
);

  for (genvar b = 0; b < LANES; b++) begin : g_byte
    logic [OFS_W-1:0] lane;
    logic             used;
    always_comb begin
      used = !misalign && (OFS_W'(b) <= last);
      if (swap) lane = ofs + last - OFS_W'(b);
      else      lane = ofs + OFS_W'(b);
      dst[b*LANE_W +: LANE_W] = used ? lanes[lane*LANE_W +: LANE_W] : '0;
    end
  end

endmodule

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFS_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_en,
  input  logic              req_store,
  input  logic [1:0]        req_size,
  input  logic [OFS_W-1:0]  req_ofs,
  input  logic [1:0]        req_cls,
  input  logic              little_en,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [LANES-1:0]  bus_be,
  output logic              misalign,
  output logic [DATA_W-1:0] ld_data,
  output logic              out_vld
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [LANES-1:0]  dec_be;
  logic              dec_mis;
  logic              dec_swap;
  logic [OFS_W-1:0]  dec_last;
  logic [DATA_W-1:0] wr_lanes;
  logic [DATA_W-1:0] rd_value;

  lsteer_decode #(.LANES(LANES)) u_decode (
    .size     (req_size),
    .ofs      (req_ofs),
    .cls      (req_cls),
    .little   (little_en),
    .be       (dec_be),
    .misalign (dec_mis),
    .swap     (dec_swap),
    .last     (dec_last)
  );

  lsteer_wr_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_wr_mux (
    .src   (st_data),
    .be    (dec_be),
    .ofs   (req_ofs),
    .last  (dec_last),
    .swap  (dec_swap),
    .lanes (wr_lanes)
  );

  lsteer_rd_mux #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_mux (
    .lanes    (bus_rdata),
    .misalign (dec_mis),
    .ofs      (req_ofs),
    .last     (dec_last),
    .swap     (dec_swap),
    .dst      (rd_value)
  );

  // next-state
  logic [DATA_W-1:0] wdata_d, ld_d;
  logic [LANES-1:0]  be_d;
  logic              mis_d;

  always_comb begin
    be_d    = dec_be;
    mis_d   = dec_mis;
    wdata_d = req_store ? wr_lanes : '0;
    ld_d    = req_store ? '0 : rd_value;
  end

  // registers, clock-enabled by the request strobe
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bus_wdata <= '0;
      bus_be    <= '0;
      misalign  <= 1'b0;
      ld_data   <= '0;
    end else if (req_en) begin
      bus_wdata <= wdata_d;
      bus_be    <= be_d;
      misalign  <= mis_d;
      ld_data   <= ld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_vld <= 1'b0;
    else            out_vld <= req_en;
  end

endmodule

// File: rtl/lsteer_chk.sv
module lsteer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_en,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic [1:0]  req_ofs,
  input logic [1:0]  req_cls,
  input logic [31:0] st_data,
  input logic [31:0] bus_wdata,
  input logic [3:0]  bus_be,
  input logic        misalign,
  input logic [31:0] ld_data,
  input logic        out_vld
);

  // R6
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (bus_be == 4'b0 && bus_wdata == 32'b0 && ld_data == 32'b0));

  // R1
  byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && req_size == 2'd0) |=> (bus_be == (4'b0001 << $past(req_ofs))));

  // R1
  be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !misalign) |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                                $countones(bus_be) == 4));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_en |=> (!out_vld && $stable(bus_wdata) && $stable(bus_be) && $stable(ld_data)));

  // R7
  load_no_wdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && !req_store) |=> (bus_wdata == 32'b0));

  // R5
  regs_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_en && req_store && req_cls == 2'd1 && req_size == 2'd2 && req_ofs == 2'd0)
      |=> (bus_wdata == $past(st_data)));

endmodule

bind lane_steer lsteer_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_en    (req_en),
  .req_store (req_store),
  .req_size  (req_size),
  .req_ofs   (req_ofs),
  .req_cls   (req_cls),
  .st_data   (st_data),
  .bus_wdata (bus_wdata),
  .bus_be    (bus_be),
  .misalign  (misalign),
  .ld_data   (ld_data),
  .out_vld   (out_vld)
);

// File: tb/lane_steer_bench.sv
`timescale 1ns/1ps
module lane_steer_bench;

  logic        clk;
  logic        rst_n;
  logic        req_en, req_store, little_en;
  logic [1:0]  req_size, req_ofs, req_cls;
  logic [31:0] st_data, bus_rdata;
  logic [31:0] bus_wdata, ld_data;
  logic [3:0]  bus_be;
  logic        misalign, out_vld;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  lane_steer u_lane_steer (
    .clk(clk), .rst_n(rst_n), .req_en(req_en), .req_store(req_store),
    .req_size(req_size), .req_ofs(req_ofs), .req_cls(req_cls),
    .little_en(little_en), .st_data(st_data), .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .misalign(misalign),
    .ld_data(ld_data), .out_vld(out_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic [1:0]  of;
    logic [1:0]  cl;
    logic        le;
    logic [31:0] sd;
    logic [31:0] rd;
    logic [31:0] wd;
    logic [3:0]  be;
    logic        mis;
    logic [31:0] ld;
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    // R2 LE word store, unchanged
    {1'b1,2'd2,2'd0,2'd0,1'b1,32'h01020304,32'h0,32'h01020304,4'hF,1'b0,32'h0,4'd2},
    // R3 BE word store, reversed
    {1'b1,2'd2,2'd0,2'd0,1'b0,32'h01020304,32'h0,32'h04030201,4'hF,1'b0,32'h0,4'd3},
    // R2 LE half offset 2
    {1'b1,2'd1,2'd2,2'd0,1'b1,32'h55660304,32'h0,32'h03040000,4'hC,1'b0,32'h0,4'd2},
    // R1 LE half offset 0
    {1'b1,2'd1,2'd0,2'd0,1'b1,32'h55660304,32'h0,32'h00000304,4'h3,1'b0,32'h0,4'd1},
    // R3 BE half offset 0
    {1'b1,2'd1,2'd0,2'd0,1'b0,32'h55660304,32'h0,32'h00000403,4'h3,1'b0,32'h0,4'd3},
    // R3 BE half offset 2
    {1'b1,2'd1,2'd2,2'd0,1'b0,32'h55660304,32'h0,32'h04030000,4'hC,1'b0,32'h0,4'd3},
    // R1 LE byte offset 3
    {1'b1,2'd0,2'd3,2'd0,1'b1,32'h000000AB,32'h0,32'hAB000000,4'h8,1'b0,32'h0,4'd1},
    // R1 BE byte offset 1
    {1'b1,2'd0,2'd1,2'd0,1'b0,32'h123456AB,32'h0,32'h0000AB00,4'h2,1'b0,32'h0,4'd1},
    // R4 BE byte load offset 0 -> 0x04
    {1'b0,2'd0,2'd0,2'd0,1'b0,32'h0,32'h07060504,32'h0,4'h1,1'b0,32'h00000004,4'd4},
    // R4 LE byte load offset 0 -> 0x07
    {1'b0,2'd0,2'd0,2'd0,1'b1,32'h0,32'h04050607,32'h0,4'h1,1'b0,32'h00000007,4'd4},
    // R4 BE word load
    {1'b0,2'd2,2'd0,2'd0,1'b0,32'h0,32'h07060504,32'h0,4'hF,1'b0,32'h04050607,4'd4},
    // R4 LE word load
    {1'b0,2'd2,2'd0,2'd0,1'b1,32'h0,32'h04050607,32'h0,4'hF,1'b0,32'h04050607,4'd4},
    // R4 LE half load offset 2
    {1'b0,2'd1,2'd2,2'd0,1'b1,32'h0,32'h04050607,32'h0,4'hC,1'b0,32'h00000405,4'd4},
    // R4 BE half load offset 2
    {1'b0,2'd1,2'd2,2'd0,1'b0,32'h0,32'h04050607,32'h0,4'hC,1'b0,32'h00000504,4'd4},
    // R5 register space, BE word store, no swap
    {1'b1,2'd2,2'd0,2'd1,1'b0,32'h01020304,32'h0,32'h01020304,4'hF,1'b0,32'h0,4'd5},
    // R5 register space, BE half load, no swap
    {1'b0,2'd1,2'd0,2'd1,1'b0,32'h0,32'h07060504,32'h0,4'h3,1'b0,32'h00000504,4'd5},
    // R5 data port, BE word store, swapped
    {1'b1,2'd2,2'd0,2'd2,1'b0,32'h01020304,32'h0,32'h04030201,4'hF,1'b0,32'h0,4'd5},
    // R5 reserved class acts as memory
    {1'b1,2'd2,2'd0,2'd3,1'b0,32'h01020304,32'h0,32'h04030201,4'hF,1'b0,32'h0,4'd5},
    // R6 half at odd offset
    {1'b1,2'd1,2'd1,2'd0,1'b1,32'h01020304,32'h0,32'h0,4'h0,1'b1,32'h0,4'd6},
    // R6 word at offset 2, load
    {1'b0,2'd2,2'd2,2'd0,1'b0,32'h0,32'hFFFFFFFF,32'h0,4'h0,1'b1,32'h0,4'd6},
    // R6 reserved size
    {1'b1,2'd3,2'd0,2'd0,1'b1,32'hFFFFFFFF,32'hFFFFFFFF,32'h0,4'h0,1'b1,32'h0,4'd6},
    // R7 load ignores store data
    {1'b0,2'd2,2'd0,2'd0,1'b1,32'hFFFFFFFF,32'h11223344,32'h0,4'hF,1'b0,32'h11223344,4'd7},
    // R7 store ignores read data
    {1'b1,2'd0,2'd0,2'd0,1'b1,32'h000000AB,32'hFFFFFFFF,32'h000000AB,4'h1,1'b0,32'h0,4'd7}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    req_store = v.st; req_size = v.sz; req_ofs = v.of; req_cls = v.cl;
    little_en = v.le; st_data = v.sd; bus_rdata = v.rd;
  endtask

  task automatic check_zero(input string req);
    chk(req, "wdata", bus_wdata, 32'h0);
    chk(req, "be", {28'h0, bus_be}, 32'h0);
    chk(req, "misalign", {31'h0, misalign}, 32'h0);
    chk(req, "ld", ld_data, 32'h0);
    chk(req, "vld", {31'h0, out_vld}, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_en = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    check_zero("R9");  // reset state
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d", VEC[i].tag);
      drive(VEC[i]);
      req_en = 1'b1;
      @(negedge clk);
      req_en = 1'b0;
      chk(tg, "wdata", bus_wdata, VEC[i].wd);
      chk(tg, "be", {28'h0, bus_be}, {28'h0, VEC[i].be});
      chk(tg, "misalign", {31'h0, misalign}, {31'h0, VEC[i].mis});
      chk(tg, "ld", ld_data, VEC[i].ld);
      chk("R8", "vld", {31'h0, out_vld}, 32'h1);
    end

    // R8: strobe low, new inputs must not reach the outputs
    drive(VEC[0]);
    req_en = 1'b1;
    @(negedge clk);
    req_en = 1'b0;
    drive(VEC[1]);
    @(negedge clk);
    chk("R8", "vld", {31'h0, out_vld}, 32'h0);
    chk("R8", "wdata hold", bus_wdata, 32'h01020304);
    chk("R8", "be hold", {28'h0, bus_be}, 32'hF);
    repeat (2) @(negedge clk);
    chk("R8", "wdata hold late", bus_wdata, 32'h01020304);

    // R9: reset asserted mid-run clears outputs at once
    rst_n = 1'b0;
    #1;
    check_zero("R9");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_zero("R9");

    // R6 then R1: misalign flag clears on the next aligned request
    drive(VEC[18]);
    req_en = 1'b1;
    @(negedge clk);
    drive(VEC[6]);
    @(negedge clk);
    req_en = 1'b0;
    chk("R6", "misalign cleared", {31'h0, misalign}, 32'h0);
    chk("R1", "be after misalign", {28'h0, bus_be}, 32'h8);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule